// File: doc/BRIEF.md
# Per-Pin Interrupt Detector

This block watches a small group of input pins (eight by default) and decides, separately for each pin, whether an interrupt condition has occurred. Every pin can be set to respond to a rising edge, a falling edge, either edge, a high level or a low level. A detected condition is recorded in a per-pin pending bit. Software acknowledges it through a one-cycle write-one-to-clear strobe. A single port interrupt line is raised whenever an enabled pin has its pending bit set.

The pins are expected to be synchronised to `clk` before they reach the block. Edges are found by comparing each pin with its value one cycle earlier. An edge that arrives in the same cycle as its clear is kept, so an acknowledge never hides a fresh event. In level mode the pending bit simply tracks whether the pin is at its active level, so acknowledging a level that is still present does not clear it.

Top module: `pin_irq_detect`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `pend` is all zeros and `port_irq` is 0.
- R2: The trigger code for pin n is spread over three bits of `trig_cfg`: bit n is the polarity, bit n+NPINS selects edge mode, and bit n+2*NPINS selects both-edge mode. Each pin is decoded only from its own three bits.
- R3: With code (both, edge, polarity) = (0,1,1), a 0-to-1 change on the pin between two consecutive cycles sets the pin's pending bit at the clock edge that samples the 1.
- R4: With code (0,1,0), a 1-to-0 change sets the pending bit, and a 0-to-1 change does not.
- R5: With code (1,1,x), a change in either direction sets the pending bit.
- R6: With code (x,0,1), the pending bit is 1 after each edge where the sampled pin is 1 and 0 after each edge where it is 0.
- R7: With code (x,0,0), the pending bit is 1 after each edge where the sampled pin is 0 and 0 after each edge where it is 1.
- R8: In edge mode, the pending bit stays set until a `clr_strobe` bit for that pin is sampled. It is 0 after that edge if no new edge arrived with the strobe.
- R9: In edge mode, if an edge and a clear strobe for the same pin are sampled at the same clock edge, the pending bit is 1 afterwards.
- R10: In level mode, a clear strobe has no effect while the active level persists: the pending bit stays 1.
- R11: `port_irq` equals the OR over all pins of (pending bit AND `irq_en` bit). It updates at the same edge as `pend`. Pins that are not enabled still record pending status.
- R12: At the first clock edge after `rst` falls, no edge is reported. A pin that is already high when reset ends does not count as rising.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | NPINS | Synchronised pin levels |
| irq_en | input | NPINS | Per-pin interrupt enable |
| trig_cfg | input | 3*NPINS | Trigger codes: polarity, edge and both-edge bytes |
| clr_strobe | input | NPINS | Write-one-to-clear strobe for pending bits |
| pend | output | NPINS | Registered pending status per pin |
| port_irq | output | 1 | Registered port interrupt |

## Verification
The bench builds the block at the default NPINS = 8, so the three configuration fields are full bytes. Each pin can be given a different trigger code while its neighbours stay on rising-edge with static levels. This makes a decode that reads the wrong byte or the wrong bit show up as a stray or missing pending bit on a neighbouring pin. The width also leaves room to hold one disabled pin beside enabled idle ones, which exposes a masking fault on `port_irq`.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  typedef enum logic [2:0] {
    TK_LVL_LO = 3'd0,
    TK_LVL_HI = 3'd1,
    TK_RISE   = 3'd2,
    TK_FALL   = 3'd3,
    TK_BOTH   = 3'd4
  } trig_kind_e;

  // both / edge / polarity bits of one pin to a trigger kind
  function automatic trig_kind_e kind_of(input logic both, input logic edg,
                                         input logic pol);
    if (!edg)      return pol ? TK_LVL_HI : TK_LVL_LO;
    else if (both) return TK_BOTH;
    else           return pol ? TK_RISE : TK_FALL;
  endfunction

endpackage

// File: rtl/pin_irq_decode.sv
module pin_irq_decode
  import pin_irq_pkg::*;
(
  input  logic       both_bit,
  input  logic       edge_bit,
  input  logic       pol_bit,
  output trig_kind_e kind,
  output logic       is_edge
);
  always_comb begin
    kind    = kind_of(both_bit, edge_bit, pol_bit);
    is_edge = (kind == TK_RISE) || (kind == TK_FALL) || (kind == TK_BOTH);
  end
endmodule

// File: rtl/pin_irq_cell.sv
module pin_irq_cell
  import pin_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       primed,
  input  logic       pin,
  input  logic       clr,
  input  trig_kind_e kind,
  input  logic       is_edge,
  output logic       status_nxt,
  output logic       status
);
  logic pin_q;
  logic rose, dropped, hit, lvl_active;

  always_comb begin
    rose    = primed & pin & ~pin_q;
    dropped = primed & ~pin & pin_q;
    unique case (kind)
      TK_RISE: hit = rose;
      TK_FALL: hit = dropped;
      TK_BOTH: hit = rose | dropped;
      default: hit = 1'b0;
    endcase
    lvl_active = (kind == TK_LVL_HI) ? pin : ~pin;
    if (is_edge) status_nxt = hit | (status & ~clr);
    else         status_nxt = lvl_active;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= 1'b0;
      status <= 1'b0;
    end else begin
      pin_q  <= pin;
      status <= status_nxt;
    end
  end
endmodule

// File: rtl/pin_irq_merge.sv
module pin_irq_merge #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] status_nxt,
  input  logic [NPINS-1:0] enable,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status_nxt & enable);
  end
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPINS-1:0]   pin_in,
  input  logic [NPINS-1:0]   irq_en,
  input  logic [3*NPINS-1:0] trig_cfg,
  input  logic [NPINS-1:0]   clr_strobe,
  output logic [NPINS-1:0]   pend,
  output logic               port_irq
);
  localparam int EDGE_LSB = NPINS;
  localparam int BOTH_LSB = 2 * NPINS;

  logic             primed;
  logic [NPINS-1:0] nxt_vec;

  // first sample after reset only loads history
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    trig_kind_e kind;
    logic       is_edge;

    pin_irq_decode u_dec (
      .both_bit (trig_cfg[BOTH_LSB + g]),
      .edge_bit (trig_cfg[EDGE_LSB + g]),
      .pol_bit  (trig_cfg[g]),
      .kind     (kind),
      .is_edge  (is_edge)
    );

    pin_irq_cell u_cell (
      .clk        (clk),
      .rst        (rst),
      .primed     (primed),
      .pin        (pin_in[g]),
      .clr        (clr_strobe[g]),
      .kind       (kind),
      .is_edge    (is_edge),
      .status_nxt (nxt_vec[g]),
      .status     (pend[g])
    );
  end

  pin_irq_merge #(.NPINS(NPINS)) u_merge (
    .clk        (clk),
    .rst        (rst),
    .status_nxt (nxt_vec),
    .enable     (irq_en),
    .irq        (port_irq)
  );
endmodule

// File: rtl/pin_irq_detect_chk.sv
module pin_irq_detect_chk #(
  parameter int NPINS = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NPINS-1:0]   pin_in,
  input logic [NPINS-1:0]   irq_en,
  input logic [3*NPINS-1:0] trig_cfg,
  input logic [NPINS-1:0]   clr_strobe,
  input logic [NPINS-1:0]   pend,
  input logic               port_irq
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (pend == '0) && !port_irq);

  // R11
  irq_merge_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> port_irq == |(pend & $past(irq_en)));

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    // R6
    // R7
    level_track_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(trig_cfg[NPINS+i]))
      |-> pend[i] == ($past(pin_in[i]) == $past(trig_cfg[i])));

    // R8
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(trig_cfg[NPINS+i]) && !$past(clr_strobe[i])
       && $past(trig_cfg[NPINS+i], 2))
      |-> !$fell(pend[i]));

    // R9
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2) && $past(trig_cfg[NPINS+i])
       && $past(trig_cfg[2*NPINS+i]) && $past(clr_strobe[i])
       && ($past(pin_in[i]) != $past(pin_in[i], 2)))
      |-> pend[i]);

    // R12
    prime_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(rst, 2) && !$past(rst) && $past(trig_cfg[NPINS+i]))
      |-> !pend[i]);
  end
endmodule

bind pin_irq_detect pin_irq_detect_chk #(.NPINS(NPINS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pin_in     (pin_in),
  .irq_en     (irq_en),
  .trig_cfg   (trig_cfg),
  .clr_strobe (clr_strobe),
  .pend       (pend),
  .port_irq   (port_irq)
);

// File: tb/test_pin_irq_detect.sv
module test_pin_irq_detect;
  localparam int NP = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NP-1:0]   pin_in = '0;
  logic [NP-1:0]   irq_en = '0;
  logic [3*NP-1:0] trig_cfg = '0;
  logic [NP-1:0]   clr_strobe = '0;
  logic [NP-1:0]   pend;
  logic            port_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pin_irq_detect #(.NPINS(NP)) i_pin_irq_detect (
    .clk(clk), .rst(rst), .pin_in(pin_in), .irq_en(irq_en),
    .trig_cfg(trig_cfg), .clr_strobe(clr_strobe),
    .pend(pend), .port_irq(port_irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R2 layout: polarity at n, edge at n+NP, both at n+2*NP
  task automatic set_code(input int n, input bit b, input bit e, input bit p);
    trig_cfg[n]        = p;
    trig_cfg[NP + n]   = e;
    trig_cfg[2*NP + n] = b;
  endtask

  task automatic clear_pin(input int n);
    clr_strobe[n] = 1'b1;
    tick();
    clr_strobe = '0;
  endtask

  task automatic t_reset();
    for (int n = 0; n < NP; n++) set_code(n, 0, 1, 1);
    irq_en = '1;
    tick(); tick();
    check("R1 pend", pend, 0);
    check("R1 irq", port_irq, 0);
    rst = 1'b0;
    pin_in = 8'h01;
    tick();
    check("R1 pend after reset", pend, 0);
    tick();
    check("R12 no edge at first sample", pend, 0);
    check("R12 irq", port_irq, 0);
  endtask

  task automatic t_rise();
    pin_in[1] = 1'b1;
    tick();
    check("R3 rise pend", pend, 8'h02);
    check("R11 irq on rise", port_irq, 1);
    pin_in[1] = 1'b0;
    tick();
    check("R8 held", pend, 8'h02);
    clear_pin(1);
    check("R8 cleared", pend, 0);
    check("R11 irq dropped", port_irq, 0);
  endtask

  task automatic t_fall();
    set_code(2, 0, 1, 0);
    pin_in[2] = 1'b1;
    tick();
    check("R4 no set on rise", pend, 0);
    pin_in[2] = 1'b0;
    tick();
    check("R4 fall pend R2", pend, 8'h04);
    clear_pin(2);
    check("R8 fall cleared", pend, 0);
    set_code(2, 0, 1, 1);
  endtask

  task automatic t_both();
    set_code(3, 1, 1, 0);
    pin_in[3] = 1'b1;
    tick();
    check("R5 rise", pend, 8'h08);
    clear_pin(3);
    check("R5 cleared", pend, 0);
    pin_in[3] = 1'b0;
    tick();
    check("R5 fall", pend, 8'h08);
    clear_pin(3);
    set_code(3, 0, 1, 1);
    check("R5 cleared again", pend, 0);
  endtask

  task automatic t_level_high();
    set_code(4, 0, 0, 1);
    tick();
    check("R6 low pin", pend, 0);
    pin_in[4] = 1'b1;
    tick();
    check("R6 high pin", pend, 8'h10);
    clear_pin(4);
    check("R10 clear ignored", pend, 8'h10);
    check("R10 irq stays", port_irq, 1);
    pin_in[4] = 1'b0;
    tick();
    check("R6 follows low", pend, 0);
    set_code(4, 0, 1, 1);
  endtask

  task automatic t_level_low();
    set_code(5, 0, 0, 0);
    pin_in[5] = 1'b1;
    tick();
    check("R7 high pin", pend, 0);
    pin_in[5] = 1'b0;
    tick();
    check("R7 low pin", pend, 8'h20);
    pin_in[5] = 1'b1;
    tick();
    check("R7 back high", pend, 0);
    set_code(5, 0, 1, 1);
    tick();
    check("R7 restored idle", pend, 0);
  endtask

  task automatic t_same_cycle();
    pin_in[6] = 1'b1;
    clr_strobe[6] = 1'b1;
    tick();
    clr_strobe = '0;
    check("R9 edge wins", pend, 8'h40);
    clear_pin(6);
    check("R9 then cleared", pend, 0);
  endtask

  task automatic t_enable();
    irq_en = 8'h7F;
    pin_in[7] = 1'b1;
    tick();
    check("R11 disabled records", pend, 8'h80);
    check("R11 disabled masked", port_irq, 0);
    irq_en = 8'hFF;
    tick();
    check("R11 enabled", port_irq, 1);
    clear_pin(7);
    check("R11 cleared", port_irq, 0);
  endtask

  initial begin
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_level_high();
    t_level_low();
    t_same_cycle();
    t_enable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule